// File: doc/BRIEF.md
# Cartridge Control Register Bank with DMA Write Snooping

This block sits on the host CPU's byte-wide memory bus inside a cartridge coprocessor. It decodes eight byte-wide control registers inside a register window of the host address map. Two of those registers are a DMA-processing enable byte and a process-next-transfer byte. Four are bank-select bytes that drive an external ROM mapper. Reads that miss its own registers are answered from a pass-through data input. Writes that miss its own registers are forwarded downstream through a strobe output.

The block also watches host writes aimed at the host's DMA controller, without taking part in them. From these writes it keeps a shadow copy of each of eight channels' 24-bit source address and 16-bit transfer length, so the coprocessor knows where each transfer will read and how far. The snooped writes are still forwarded downstream unchanged. A needs-initialisation flag is raised by reset and is exported.

Top module: `cart_regbank`

## Requirements
- R1: When reset is held low at a clock edge, bank-select bytes 0 to 3 hold 0x00, 0x01, 0x02 and 0x03. The enable byte, the next-transfer byte, and all snooped addresses and lengths become zero. init_req becomes 1.
- R2: The block decodes a register window in banks 0x00–0x3F and 0x80–0xBF (address bit 22 clear) over 16-bit offsets 0x4000–0x4FFF. Its own registers are 0x4800–0x4807 of that window, selected by address bits 2:0. A write to offset 0 loads dma_en, and a write to offset 1 loads dma_next. The new value shows on the outputs after the clock edge on which bus_wr is high.
- R3: A write to offsets 4–7 loads the bank-select byte indexed by address bits 1:0. bank_sel carries byte i on bits 8i+7:8i. The other bank bytes keep their values.
- R4: A read of own offsets 0, 1 or 4–7 returns the stored byte in the same cycle. Offsets 2 and 3 read 0x00, and writes to them change no output.
- R5: While bus_rd is high, any address other than an own register returns down_rdata on bus_rdata in the same cycle. While bus_rd is low, bus_rdata is 0x00.
- R6: fwd_wr equals bus_wr in the same cycle, except that it is 0 for a write to an own register.
- R7: A write to 0x4300–0x437A inside the window is snooped on channel = address bits 6:4. Low nibble 2, 3 or 4 replaces bits 7:0, 15:8 or 23:16 of that channel's address. Channel c's address is on snoop_addr bits 24c+23:24c.
- R8: A snooped write with low nibble 5 replaces length bits 7:0, and one with low nibble 6 replaces bits 15:8. Channel c's length is on snoop_len bits 16c+15:16c.
- R9: Snooped writes with any other low nibble, and writes at 0x437B and above, change no snooped value.
- R10: In banks 0x40–0x7F and 0xC0–0xFF, addresses 0x4800–0x4807 and 0x43xx are neither decoded nor snooped. Such reads return down_rdata, and such writes are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Host address, bank in bits 23:16 |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 8 | Read data to host |
| down_rdata | input | 8 | Read data from downstream handler |
| fwd_wr | output | 1 | Write forwarded downstream |
| bank_sel | output | 32 | Four bank-select bytes |
| dma_en | output | 8 | DMA-processing enable byte |
| dma_next | output | 8 | Process-next-transfer byte |
| snoop_addr | output | 192 | Shadow 24-bit address per channel |
| snoop_len | output | 128 | Shadow 16-bit length per channel |
| init_req | output | 1 | Needs-initialisation flag |

## Verification
bus_rdata and fwd_wr are combinational, so they are due in the same cycle as the strobe. Every register and snooped value is due one clock edge after the write cycle. The driver applies each access just after a rising edge and queues its expectations. The monitor compares queued items on the following falling edge. The same-cycle results are therefore sampled while the access is still applied. Register contents are checked on an idle cycle after the write edge, and are never checked during the write cycle itself.

// File: rtl/cart_regbank_pkg.sv
// Package: shared constants and the decode record for the cartridge register bank.
// Assumes a 24-bit host address with the bank number in bits 23:16.
package cart_regbank_pkg;
    localparam int ADDR_W    = 24;
    localparam int DATA_W    = 8;
    localparam int NUM_CH    = 8;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int NUM_BANK  = 4;
    localparam int BANK_W    = $clog2(NUM_BANK);
    localparam int SADDR_W   = 24;
    localparam int SLEN_W    = 16;
    localparam int OFF_W     = 3;

    localparam logic [15:0] OWN_BASE   = 16'h4800;
    localparam logic [7:0]  SNOOP_PAGE = 8'h43;
    localparam logic [7:0]  SNOOP_LAST = 8'h7A;
    localparam logic [3:0]  WIN_NIB    = 4'h4;

    typedef struct packed {
        logic             own_hit;
        logic [OFF_W-1:0] own_off;
        logic             snp_hit;
        logic [CH_W-1:0]  snp_ch;
        logic [3:0]       snp_nib;
    } crb_dec_t;
endpackage

// File: rtl/crb_decode.sv
// Address decoder: classifies a host address as an own-register hit and/or a
// DMA-controller snoop hit. Purely combinational.
// Assumes the window exists only where bank bit 22 is clear.
module crb_decode
    import cart_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output crb_dec_t          dec
);
    logic in_win;
    logic unused_bank_bits;

    // Bits of the bank number that play no part in the window decode.
    assign unused_bank_bits = ^{addr[23], addr[21:16]};

    // Build the decode record from the window, own-register and snoop ranges.
    always_comb begin
        in_win      = !addr[22] && (addr[15:12] == WIN_NIB);
        dec.own_hit = in_win && (addr[15:OFF_W] == OWN_BASE[15:OFF_W]);
        dec.own_off = addr[OFF_W-1:0];
        dec.snp_hit = in_win && (addr[15:8] == SNOOP_PAGE) && (addr[7:0] <= SNOOP_LAST);
        dec.snp_ch  = addr[4 +: CH_W];
        dec.snp_nib = addr[3:0];
    end
endmodule

// File: rtl/crb_ctrl_regs.sv
// Control registers: enable byte, next-transfer byte, bank-select bytes and the
// needs-init flag, plus the own-register read mux.
// Assumes wr_hit is already qualified by the own-register decode.
module crb_ctrl_regs
    import cart_regbank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_hit,
    input  logic [OFF_W-1:0]              off,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             en_q,
    output logic [DATA_W-1:0]             nxt_q,
    output logic [NUM_BANK-1:0][DATA_W-1:0] bank_q,
    output logic                          init_q,
    output logic [DATA_W-1:0]             rd_val
);
    // Enable, next-transfer and needs-init registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            nxt_q  <= '0;
            init_q <= 1'b1;
        end else if (wr_hit) begin
            if (off == 3'd0) en_q  <= wdata;
            if (off == 3'd1) nxt_q <= wdata;
        end
    end

    // One bank-select register per slot, each reset to its own index.
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[b] <= DATA_W'(b);
            else if (wr_hit && off[2] && (off[BANK_W-1:0] == BANK_W'(b)))
                bank_q[b] <= wdata;
        end
    end

    // Read mux over the eight own offsets; 2 and 3 read as zero.
    always_comb begin
        case (off)
            3'd0:    rd_val = en_q;
            3'd1:    rd_val = nxt_q;
            3'd4, 3'd5, 3'd6, 3'd7: rd_val = bank_q[off[BANK_W-1:0]];
            default: rd_val = '0;
        endcase
    end

    assert_en_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off == 3'd0) |=> (en_q == $past(wdata)));

    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && off[2]) |=> $stable(bank_q));

    assert_gap_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && off[2:1] == 2'b01) |=> ($stable(en_q) && $stable(nxt_q) && $stable(bank_q)));
endmodule

// File: rtl/crb_dma_snoop.sv
// DMA snoop: keeps a shadow copy of each channel's source address and length
// from host writes to the DMA controller. Assumes wr is already range-qualified.
module crb_dma_snoop
    import cart_regbank_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [CH_W-1:0]                    ch,
    input  logic [3:0]                         nib,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_CH-1:0][SADDR_W-1:0]     addr_q,
    output logic [NUM_CH-1:0][SLEN_W-1:0]      len_q
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = wr && (ch == CH_W'(c));

        // Byte-lane update of this channel's shadow address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                addr_q[c] <= '0;
            else if (sel) begin
                if (nib == 4'h2) addr_q[c][7:0]   <= wdata;
                if (nib == 4'h3) addr_q[c][15:8]  <= wdata;
                if (nib == 4'h4) addr_q[c][23:16] <= wdata;
            end
        end

        // Byte-lane update of this channel's shadow length.
        always_ff @(posedge clk) begin
            if (!rst_n)
                len_q[c] <= '0;
            else if (sel) begin
                if (nib == 4'h5) len_q[c][7:0]  <= wdata;
                if (nib == 4'h6) len_q[c][15:8] <= wdata;
            end
        end
    end

    assert_addr_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && nib == 4'h2) |=> (addr_q[$past(ch)][7:0] == $past(wdata)));

    assert_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (nib == 4'h5 || nib == 4'h6)) |=> $stable(len_q));
endmodule

// File: rtl/cart_regbank.sv
// Top: cartridge register bank with DMA write snooping. Combinational read
// path and forward strobe; registered state updates on the write-strobe edge.
// Assumes one access per cycle and the bus held stable within a cycle.
module cart_regbank
    import cart_regbank_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [DATA_W-1:0]           down_rdata,
    output logic                        fwd_wr,
    output logic [NUM_BANK*DATA_W-1:0]  bank_sel,
    output logic [DATA_W-1:0]           dma_en,
    output logic [DATA_W-1:0]           dma_next,
    output logic [NUM_CH*SADDR_W-1:0]   snoop_addr,
    output logic [NUM_CH*SLEN_W-1:0]    snoop_len,
    output logic                        init_req
);
    crb_dec_t                        dec;
    logic [DATA_W-1:0]               own_rd;
    logic [NUM_BANK-1:0][DATA_W-1:0] bank_q;
    logic [NUM_CH-1:0][SADDR_W-1:0]  saddr_q;
    logic [NUM_CH-1:0][SLEN_W-1:0]   slen_q;
    logic                            snp_wr;

    crb_decode u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    crb_ctrl_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (bus_wr && dec.own_hit),
        .off    (dec.own_off),
        .wdata  (bus_wdata),
        .en_q   (dma_en),
        .nxt_q  (dma_next),
        .bank_q (bank_q),
        .init_q (init_req),
        .rd_val (own_rd)
    );

    assign snp_wr = bus_wr && dec.snp_hit;

    crb_dma_snoop u_snoop (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (snp_wr),
        .ch     (dec.snp_ch),
        .nib    (dec.snp_nib),
        .wdata  (bus_wdata),
        .addr_q (saddr_q),
        .len_q  (slen_q)
    );

    // Read data: own register on a hit, else pass-through, zero when idle.
    always_comb begin
        if (!bus_rd)          bus_rdata = '0;
        else if (dec.own_hit) bus_rdata = own_rd;
        else                  bus_rdata = down_rdata;
    end

    // Forward every write except those claimed by own registers.
    assign fwd_wr = bus_wr && !dec.own_hit;

    assign bank_sel   = bank_q;
    assign snoop_addr = saddr_q;
    assign snoop_len  = slen_q;

    assert_snoop_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wr |-> fwd_wr);
endmodule

// File: tb/cart_regbank_tb.sv
module cart_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [23:0]  bus_addr;
    logic [7:0]   bus_wdata;
    logic         bus_rd;
    logic         bus_wr;
    logic [7:0]   bus_rdata;
    logic [7:0]   down_rdata;
    logic         fwd_wr;
    logic [31:0]  bank_sel;
    logic [7:0]   dma_en;
    logic [7:0]   dma_next;
    logic [191:0] snoop_addr;
    logic [127:0] snoop_len;
    logic         init_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .down_rdata(down_rdata), .fwd_wr(fwd_wr), .bank_sel(bank_sel),
        .dma_en(dma_en), .dma_next(dma_next), .snoop_addr(snoop_addr),
        .snoop_len(snoop_len), .init_req(init_req)
    );

    typedef struct {
        int          sel;
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference model kept from the requirements.
    logic [7:0]  m_bank [4];
    logic [7:0]  m_en, m_nxt;
    logic [23:0] m_addr [8];
    logic [15:0] m_len  [8];

    function automatic logic [31:0] observe(int sel, int idx);
        case (sel)
            0: return {24'h0, bus_rdata};
            1: return {31'h0, fwd_wr};
            2: return {24'h0, bank_sel[idx*8 +: 8]};
            3: return {24'h0, dma_en};
            4: return {24'h0, dma_next};
            5: return {8'h0, snoop_addr[idx*24 +: 24]};
            6: return {16'h0, snoop_len[idx*16 +: 16]};
            default: return {31'h0, init_req};
        endcase
    endfunction

    // Monitor: compare all queued expectations away from the active edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = observe(it.sel, it.idx);
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d idx=%0d actual=%h expected=%h",
                         it.req, it.sel, it.idx, act, it.exp);
            end
        end
    end

    task automatic push(int sel, int idx, logic [31:0] exp, string req);
        item_t it;
        it.sel = sel; it.idx = idx; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 4; i++) m_bank[i] = 8'(i);
        m_en = 0; m_nxt = 0;
        for (int i = 0; i < 8; i++) begin m_addr[i] = 0; m_len[i] = 0; end
    endfunction

    function automatic bit is_own(logic [23:0] a);
        return !a[22] && a[15:0] >= 16'h4800 && a[15:0] <= 16'h4807;
    endfunction

    function automatic logic [7:0] own_val(logic [23:0] a);
        case (a[2:0])
            3'd0: return m_en;
            3'd1: return m_nxt;
            3'd2, 3'd3: return 8'h00;
            default: return m_bank[a[1:0]];
        endcase
    endfunction

    // Model update for one write, effective after the clock edge.
    function automatic void model_write(logic [23:0] a, logic [7:0] d);
        if (is_own(a)) begin
            if (a[2:0] == 3'd0) m_en = d;
            else if (a[2:0] == 3'd1) m_nxt = d;
            else if (a[2]) m_bank[a[1:0]] = d;
        end else if (!a[22] && a[15:0] >= 16'h4300 && a[15:0] <= 16'h437A) begin
            int c;
            c = int'(a[6:4]);
            case (a[3:0])
                4'h2: m_addr[c][7:0]   = d;
                4'h3: m_addr[c][15:8]  = d;
                4'h4: m_addr[c][23:16] = d;
                4'h5: m_len[c][7:0]    = d;
                4'h6: m_len[c][15:8]   = d;
                default: ;
            endcase
        end
    endfunction

    task automatic drive(logic rd, logic wr, logic [23:0] a, logic [7:0] d, logic [7:0] dn);
        @(posedge clk); #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; down_rdata = dn;
    endtask

    task automatic do_write(logic [23:0] a, logic [7:0] d, string req);
        drive(1'b0, 1'b1, a, d, 8'h5A);
        push(1, 0, {31'h0, !is_own(a)}, req);
        push(0, 0, 32'h0, "R5");
        model_write(a, d);
    endtask

    task automatic do_read(logic [23:0] a, logic [7:0] dn, string req);
        drive(1'b1, 1'b0, a, 8'h00, dn);
        push(0, 0, {24'h0, is_own(a) ? own_val(a) : dn}, req);
        push(1, 0, 32'h0, "R6");
    endtask

    task automatic check_state(string req);
        drive(1'b0, 1'b0, 24'h000000, 8'h00, 8'h00);
        for (int i = 0; i < 4; i++) push(2, i, {24'h0, m_bank[i]}, req);
        push(3, 0, {24'h0, m_en}, req);
        push(4, 0, {24'h0, m_nxt}, req);
        for (int i = 0; i < 8; i++) begin
            push(5, i, {8'h0, m_addr[i]}, req);
            push(6, i, {16'h0, m_len[i]}, req);
        end
        push(7, 0, 32'h1, req);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; down_rdata = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; down_rdata = 0;
        do_reset();
        check_state("R1");
        do_read(24'h004804, 8'hEE, "R1");

        // R2 / R3: own register writes in both window bank ranges.
        do_write(24'h004800, 8'hA5, "R2");
        do_write(24'h834801, 8'h3C, "R2");
        do_write(24'h104806, 8'h77, "R3");
        do_write(24'hBF4807, 8'h81, "R3");
        check_state("R3");
        do_read(24'h004800, 8'h11, "R4");
        do_read(24'h004801, 8'h11, "R4");
        do_read(24'h804806, 8'h11, "R4");

        // R4: gap offsets read zero and ignore writes.
        do_write(24'h004802, 8'hFF, "R4");
        do_write(24'h004803, 8'hFF, "R4");
        check_state("R4");
        do_read(24'h004802, 8'h99, "R4");
        do_read(24'h004803, 8'h99, "R4");

        // R5: pass-through reads.
        do_read(24'h004808, 8'hC3, "R5");
        do_read(24'h0047FF, 8'h3C, "R5");
        do_read(24'h7E1234, 8'h42, "R5");

        // R10: banks outside the window do not decode or snoop.
        do_write(24'h404800, 8'h55, "R10");
        do_write(24'hC04805, 8'h55, "R10");
        do_write(24'h404302, 8'h55, "R10");
        do_write(24'hC04375, 8'h55, "R10");
        check_state("R10");
        do_read(24'h404800, 8'h6B, "R10");

        // R7 / R8: snooped address and length bytes on several channels.
        do_write(24'h004302, 8'h12, "R7");
        do_write(24'h004303, 8'h34, "R7");
        do_write(24'h004304, 8'h56, "R7");
        do_write(24'h004335, 8'hCD, "R8");
        do_write(24'h004336, 8'hAB, "R8");
        do_write(24'h804372, 8'h9A, "R7");
        do_write(24'h804374, 8'hFE, "R7");
        do_write(24'h004376, 8'h44, "R8");
        do_write(24'h3F4353, 8'h21, "R7");
        check_state("R7");

        // R9: other nibbles and addresses past the range change nothing.
        do_write(24'h004300, 8'hEE, "R9");
        do_write(24'h004301, 8'hEE, "R9");
        do_write(24'h004317, 8'hEE, "R9");
        do_write(24'h00437B, 8'hEE, "R9");
        do_write(24'h004382, 8'hEE, "R9");
        do_write(24'h004392, 8'hEE, "R9");
        check_state("R9");

        // R6: forward strobe idle cycle.
        drive(1'b0, 1'b0, 24'h004800, 8'h00, 8'h00);
        push(1, 0, 32'h0, "R6");

        // R1: reset after activity restores defaults.
        do_reset();
        check_state("R1");

        @(posedge clk); @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule